// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte Enables and Parity

This block is a single-port synchronous memory. Its control inputs are all registered, and it needs no idle cycles between reads and writes. Three chip-select inputs, a write strobe, a byte-write mask and the address are sampled on each rising edge that the active-low clock enable lets through. A read returns, in the cycle after that edge, the word stored at the address sampled there. A write takes its address and byte mask at one enabled edge. Its data and parity arrive on the write-data inputs and are captured at the next enabled edge. Until then a one-stage pending-write register holds the address and the mask.

Every byte lane carries one parity bit, which is stored and returned alongside the data byte. Both bits of a lane obey the same active-low byte enable. A read that meets a pending write to the same address at the commit edge sees the new bytes merged over the old ones. The block also produces a bus-drive signal for an external tri-state data buffer. That signal is low during write-data phases and after any edge that sampled the device unselected, whatever the output-enable pin says. An asynchronous active-low output enable further gates it. A sleep input makes every new access act as a deselect and leaves the stored contents as they are.

Top module: `sram_bytewr`

## Requirements
- R1: An access is accepted only at an edge where clk_en_ni=0, sel1_ni=0, sel2_i=1, sel3_ni=0 and sleep_i=0. Any other select combination starts no read and no write.
- R2: After an accepted read (wr_ni=1) of address A, rdata_o and rpar_o show the word stored at A in the following cycle, and bus_drive_o is 1 if out_en_ni is 0.
- R3: An accepted write (wr_ni=0) samples its address and byte_wr_ni at that edge. The wdata_i/wpar_i values present at the next enabled edge are stored into byte k only when byte_wr_ni[k] was 0. Every other byte keeps its old value. Byte k is bits [8k+7:8k].
- R4: Parity bit k (wpar_i[k], rpar_o[k]) is written under the same enable as byte k and is read back together with it.
- R5: A read of address A at the edge that commits a pending write to A returns the newly written bytes merged with the unwritten old bytes.
- R6: In the cycle after an edge that accepts a write, bus_drive_o is 0.
- R7: In the cycle after an enabled edge that samples the device unselected (including sleep), bus_drive_o is 0.
- R8: While out_en_ni is 1, bus_drive_o is 0 at once, with no clock edge needed.
- R9: An edge with clk_en_ni=1 changes nothing. rdata_o, rpar_o and the drive state hold, and a pending write waits for the next enabled edge to take its data.
- R10: A write presented while sleep_i=1 leaves memory unchanged.
- R11: After reset, bus_drive_o is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the control registers |
| clk_en_ni | input | 1 | Active-low clock enable; high extends the previous cycle |
| sel1_ni | input | 1 | Chip select, active low |
| sel2_i | input | 1 | Chip select, active high |
| sel3_ni | input | 1 | Chip select, active low |
| sleep_i | input | 1 | High blocks new accesses |
| wr_ni | input | 1 | Write strobe, active low |
| byte_wr_ni | input | BYTES | Per-byte write enables, active low |
| addr_i | input | ADDR_W | Word address |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | BYTES*BYTE_W | Write data, sampled one enabled edge after the write command |
| wpar_i | input | BYTES | Write parity, one bit per byte |
| rdata_o | output | BYTES*BYTE_W | Read data |
| rpar_o | output | BYTES | Read parity |
| bus_drive_o | output | 1 | High when the external data buffer should drive the bus |

## Verification
The checker watches bus-drive gating on every cycle. It confirms that the drive is off after write and deselect edges and while output enable is high, that it comes on after reads, and that read data and the drive state hold across clock-enable stalls. Stored contents, byte-masked merging, parity tracking, the read-after-write bypass and the fact that sleep protects the memory can only be shown through bench scenarios. There, a reference memory is compared with read data across random and directed command sequences.

// File: rtl/sram_pkg.sv
package sram_pkg;
   // Decoded command sampled at an enabled edge
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
   import sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clk_en_ni,
   input  logic              sel1_ni,
   input  logic              sel2_i,
   input  logic              sel3_ni,
   input  logic              sleep_i,
   input  logic              wr_ni,
   input  logic [BYTES-1:0]  byte_wr_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              out_en_ni,
   output logic              commit_o,
   output logic [ADDR_W-1:0] commit_addr_o,
   output logic [BYTES-1:0]  commit_mask_o,
   output logic              rd_load_o,
   output logic              bypass_o,
   output logic              drive_o
);
   logic              adv;
   logic              selected;
   sram_op_e          op;
   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;
   logic [BYTES-1:0]  pend_mask;
   logic              drv_q;

   assign adv      = ~clk_en_ni;
   assign selected = ~sel1_ni & sel2_i & ~sel3_ni & ~sleep_i;

   always_comb begin
      if (!selected)  op = OP_NONE;
      else if (wr_ni) op = OP_READ;
      else            op = OP_WRITE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_mask <= '0;
         drv_q     <= 1'b0;
      end else if (adv) begin
         pend_v <= (op == OP_WRITE);
         if (op == OP_WRITE) begin
            pend_addr <= addr_i;
            pend_mask <= ~byte_wr_ni;
         end
         drv_q <= (op == OP_READ);
      end
   end

   assign commit_o      = adv & pend_v;
   assign commit_addr_o = pend_addr;
   assign commit_mask_o = pend_mask;
   assign rd_load_o     = adv & (op == OP_READ);
   assign bypass_o      = commit_o & (pend_addr == addr_i);
   assign drive_o       = drv_q & ~out_en_ni;
endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_i,
   input  logic                    wr_en_i,
   input  logic [BYTES-1:0]        wr_mask_i,
   input  logic [ADDR_W-1:0]       wr_addr_i,
   input  logic [BYTES*LANE_W-1:0] wr_word_i,
   input  logic [ADDR_W-1:0]       rd_addr_i,
   output logic [BYTES*LANE_W-1:0] rd_word_o
);
   localparam int DEPTH = 1 << ADDR_W;

   // One storage column per byte lane; each lane holds data plus parity
   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk_i) begin
         if (wr_en_i && wr_mask_i[k])
            lane_mem[wr_addr_i] <= wr_word_i[k*LANE_W +: LANE_W];
      end

      assign rd_word_o[k*LANE_W +: LANE_W] = lane_mem[rd_addr_i];
   end
endmodule

// File: rtl/sram_rdpath.sv
module sram_rdpath #(
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    load_i,
   input  logic                    bypass_i,
   input  logic [BYTES-1:0]        mask_i,
   input  logic [BYTES*LANE_W-1:0] wr_word_i,
   input  logic [BYTES*LANE_W-1:0] arr_word_i,
   output logic [BYTES*LANE_W-1:0] rd_word_o
);
   logic [BYTES*LANE_W-1:0] merged;

   // Per-lane forwarding of a write committing on this same edge
   for (genvar k = 0; k < BYTES; k++) begin : g_merge
      assign merged[k*LANE_W +: LANE_W] = (bypass_i && mask_i[k]) ?
         wr_word_i[k*LANE_W +: LANE_W] : arr_word_i[k*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rd_word_o <= '0;
      else if (load_i) rd_word_o <= merged;
   end
endmodule

// File: rtl/sram_bytewr.sv
module sram_bytewr #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    clk_en_ni,
   input  logic                    sel1_ni,
   input  logic                    sel2_i,
   input  logic                    sel3_ni,
   input  logic                    sleep_i,
   input  logic                    wr_ni,
   input  logic [BYTES-1:0]        byte_wr_ni,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    out_en_ni,
   input  logic [BYTES*BYTE_W-1:0] wdata_i,
   input  logic [BYTES-1:0]        wpar_i,
   output logic [BYTES*BYTE_W-1:0] rdata_o,
   output logic [BYTES-1:0]        rpar_o,
   output logic                    bus_drive_o
);
   localparam int LANE_W = BYTE_W + 1;
   localparam int WORD_W = BYTES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("sram_bytewr: ADDR_W out of range 1..12");
   end
   if (BYTES < 1 || BYTES > 16) begin : g_bad_bytes
      $error("sram_bytewr: BYTES out of range 1..16");
   end
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("sram_bytewr: BYTE_W must be positive");
   end

   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [BYTES-1:0]  commit_mask;
   logic              rd_load;
   logic              bypass;
   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] arr_word;
   logic [WORD_W-1:0] rd_word;

   // Pack and unpack lanes: {parity, data byte}
   for (genvar k = 0; k < BYTES; k++) begin : g_pack
      assign wr_word[k*LANE_W +: LANE_W] = {wpar_i[k], wdata_i[k*BYTE_W +: BYTE_W]};
      assign rdata_o[k*BYTE_W +: BYTE_W] = rd_word[k*LANE_W +: BYTE_W];
      assign rpar_o[k]                   = rd_word[k*LANE_W + BYTE_W];
   end

   sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .clk_en_ni     (clk_en_ni),
      .sel1_ni       (sel1_ni),
      .sel2_i        (sel2_i),
      .sel3_ni       (sel3_ni),
      .sleep_i       (sleep_i),
      .wr_ni         (wr_ni),
      .byte_wr_ni    (byte_wr_ni),
      .addr_i        (addr_i),
      .out_en_ni     (out_en_ni),
      .commit_o      (commit),
      .commit_addr_o (commit_addr),
      .commit_mask_o (commit_mask),
      .rd_load_o     (rd_load),
      .bypass_o      (bypass),
      .drive_o       (bus_drive_o)
   );

   sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_array (
      .clk_i     (clk_i),
      .wr_en_i   (commit),
      .wr_mask_i (commit_mask),
      .wr_addr_i (commit_addr),
      .wr_word_i (wr_word),
      .rd_addr_i (addr_i),
      .rd_word_o (arr_word)
   );

   sram_rdpath #(.BYTES(BYTES), .LANE_W(LANE_W)) u_rdpath (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (rd_load),
      .bypass_i   (bypass),
      .mask_i     (commit_mask),
      .wr_word_i  (wr_word),
      .arr_word_i (arr_word),
      .rd_word_o  (rd_word)
   );
endmodule

// File: rtl/sram_bytewr_chk.sv
module sram_bytewr_chk #(
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    clk_en_ni,
   input logic                    sel1_ni,
   input logic                    sel2_i,
   input logic                    sel3_ni,
   input logic                    sleep_i,
   input logic                    wr_ni,
   input logic                    out_en_ni,
   input logic [BYTES*BYTE_W-1:0] rdata_o,
   input logic [BYTES-1:0]        rpar_o,
   input logic                    bus_drive_o
);
   logic chosen;
   assign chosen = !sel1_ni && sel2_i && !sel3_ni && !sleep_i;

   // R8: output enable high blanks the bus drive
   p_oe_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_en_ni |-> !bus_drive_o);

   // R6: write data phase never drives
   p_wr_phase_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_ni && chosen && !wr_ni) |=> !bus_drive_o);

   // R7: unselected or sleeping edge never drives afterwards
   p_desel_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_ni && !chosen) |=> !bus_drive_o);

   // R2: a read drives unless output enable is high
   p_read_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_ni && chosen && wr_ni) |=> (bus_drive_o || out_en_ni));

   // R9: stalled edge holds read data and parity
   p_stall_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_en_ni |=> ($stable(rdata_o) && $stable(rpar_o)));

   // R9: stalled edge holds drive state
   p_stall_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_ni && !out_en_ni) |=> ($stable(bus_drive_o) || out_en_ni));

   // R11: leaving reset with the drive off
   p_reset_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> !bus_drive_o);
endmodule

bind sram_bytewr sram_bytewr_chk #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .clk_en_ni   (clk_en_ni),
   .sel1_ni     (sel1_ni),
   .sel2_i      (sel2_i),
   .sel3_ni     (sel3_ni),
   .sleep_i     (sleep_i),
   .wr_ni       (wr_ni),
   .out_en_ni   (out_en_ni),
   .rdata_o     (rdata_o),
   .rpar_o      (rpar_o),
   .bus_drive_o (bus_drive_o)
);

// File: tb/tb_sram_bytewr.sv
module tb_sram_bytewr;
   localparam int ADDR_W = 6;
   localparam int BYTES  = 4;
   localparam int BYTE_W = 8;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DW     = BYTES * BYTE_W;

   logic              clk_i = 1'b0;
   logic              rst_ni;
   logic              clk_en_ni, sel1_ni, sel2_i, sel3_ni, sleep_i, wr_ni, out_en_ni;
   logic [BYTES-1:0]  byte_wr_ni;
   logic [ADDR_W-1:0] addr_i;
   logic [DW-1:0]     wdata_i;
   logic [BYTES-1:0]  wpar_i;
   logic [DW-1:0]     rdata_o;
   logic [BYTES-1:0]  rpar_o;
   logic              bus_drive_o;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [DW-1:0]     m_dat [DEPTH];
   logic [BYTES-1:0]  m_par [DEPTH];
   logic              m_pv, m_drv;
   logic [ADDR_W-1:0] m_pa;
   logic [BYTES-1:0]  m_pmask;
   logic [DW+BYTES-1:0] m_rd;

   always #4ns clk_i = ~clk_i;   // 125 MHz

   sram_bytewr #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni), .sel1_ni(sel1_ni),
      .sel2_i(sel2_i), .sel3_ni(sel3_ni), .sleep_i(sleep_i), .wr_ni(wr_ni),
      .byte_wr_ni(byte_wr_ni), .addr_i(addr_i), .out_en_ni(out_en_ni),
      .wdata_i(wdata_i), .wpar_i(wpar_i), .rdata_o(rdata_o), .rpar_o(rpar_o),
      .bus_drive_o(bus_drive_o)
   );

   function automatic logic exp_drive(input logic drv, input logic oe_n);
      return drv & ~oe_n;
   endfunction

   task automatic check(input logic [DW+BYTES-1:0] act, input logic [DW+BYTES-1:0] exp,
                        input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference update for one rising edge, from the requirements
   task automatic model_edge();
      logic sel;
      if (!clk_en_ni) begin
         if (m_pv) begin
            for (int k = 0; k < BYTES; k++) begin
               if (m_pmask[k]) begin
                  m_dat[m_pa][k*BYTE_W +: BYTE_W] = wdata_i[k*BYTE_W +: BYTE_W];
                  m_par[m_pa][k] = wpar_i[k];
               end
            end
         end
         sel = !sel1_ni && sel2_i && !sel3_ni && !sleep_i;
         if (sel && !wr_ni) begin
            m_pv = 1'b1; m_pa = addr_i; m_pmask = ~byte_wr_ni; m_drv = 1'b0;
         end else begin
            m_pv = 1'b0;
            if (sel) begin
               m_drv = 1'b1;
               m_rd  = {m_par[addr_i], m_dat[addr_i]};
            end else m_drv = 1'b0;
         end
      end
   endtask

   task automatic step(input logic cen, input logic s1, input logic s2, input logic s3,
                       input logic slp, input logic we, input logic [BYTES-1:0] bw,
                       input logic [ADDR_W-1:0] a, input logic oe, input string tag);
      clk_en_ni = cen; sel1_ni = s1; sel2_i = s2; sel3_ni = s3; sleep_i = slp;
      wr_ni = we; byte_wr_ni = bw; addr_i = a; out_en_ni = oe;
      wdata_i = DW'($urandom); wpar_i = BYTES'($urandom);
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      check({{(DW+BYTES-1){1'b0}}, bus_drive_o},
            {{(DW+BYTES-1){1'b0}}, exp_drive(m_drv, out_en_ni)}, tag);
      if (m_drv) check({rpar_o, rdata_o}, m_rd, tag);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, a, 1'b0, tag);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [BYTES-1:0] bw, input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, bw, a, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, '0, 1'b0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_pv = 1'b0; m_drv = 1'b0; m_pa = '0; m_pmask = '0; m_rd = '0;
      rst_ni = 1'b0; clk_en_ni = 1'b0; sel1_ni = 1'b1; sel2_i = 1'b0; sel3_ni = 1'b1;
      sleep_i = 1'b0; wr_ni = 1'b1; byte_wr_ni = '1; addr_i = '0; out_en_ni = 1'b0;
      wdata_i = '0; wpar_i = '0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      // R11: no drive after reset
      check({{(DW+BYTES-1){1'b0}}, bus_drive_o}, '0, "R11");
      idle("R11");

      // R3: fill the memory with full-mask writes (data lands on the next edge)
      for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), '0, "R6");
      idle("R3");
      for (int i = 0; i < 8; i++) rd(ADDR_W'(i * 7), "R2");

      // R3 R4: partial write, read back later
      wr(6'd10, 4'b1010, "R6");
      idle("R3");
      rd(6'd10, "R4");

      // R5: read meets the committing write
      wr(6'd5, 4'b0101, "R6");
      rd(6'd5, "R5");
      rd(6'd5, "R3");

      // R10: write attempted while asleep
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, 6'd9, 1'b0, "R10");
      idle("R10");
      rd(6'd9, "R10");

      // R1: each select held off blocks a write
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 6'd12, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 6'd12, 1'b0, "R1");
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, 6'd12, 1'b0, "R1");
      idle("R7");
      rd(6'd12, "R1");

      // R9: stall after a read, then stall inside a late write
      rd(6'd3, "R2");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, 6'd3, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 6'd7, 1'b0, "R9");
      wr(6'd4, 4'b0011, "R6");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd4, 1'b0, "R9");
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd4, 1'b0, "R9");
      rd(6'd4, "R9");

      // R8: output enable high during a read data phase
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 6'd2, 1'b1, "R8");
      // R7 then a read straight after deselect
      idle("R7");
      rd(6'd2, "R2");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         automatic logic cen = ($urandom_range(99) < 12);
         automatic int   dk  = $urandom_range(99);
         automatic logic s1  = (dk < 5);
         automatic logic s2  = !(dk >= 5 && dk < 9);
         automatic logic s3  = (dk >= 9 && dk < 13);
         automatic logic slp = (dk >= 13 && dk < 17);
         automatic logic we  = !($urandom_range(99) < 45);
         automatic logic oe  = ($urandom_range(99) < 10);
         automatic logic [ADDR_W-1:0] a = ($urandom_range(3) == 0) ?
            ADDR_W'($urandom_range(DEPTH-1)) : ADDR_W'($urandom_range(7));
         automatic string tag;
         if (cen) tag = "R9";
         else if (s1 || !s2 || s3 || slp) tag = "R7";
         else if (!we) tag = "R6";
         else if (oe) tag = "R8";
         else tag = "R5";
         step(cen, s1, s2, s3, slp, we, BYTES'($urandom), a, oe, tag);
      end

      // drain any pending write then read the hot addresses
      idle("R3");
      for (int i = 0; i < 8; i++) rd(ADDR_W'(i), "R3");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule